// File: doc/BRIEF.md
# Linear Flash Read Cache Sequencer

This block answers 32-bit memory-mapped reads of a serial flash from a single line buffer of 1024 bytes. A read that falls inside the cached line is answered from the buffer. Any other read starts a line fill. The sequencer sends a header to a byte-wide serial transfer engine. The header holds the read instruction, three address bytes, an optional mode byte and some zero dummy bytes. The sequencer then sends 1024 zero bytes and writes the 1024 bytes that come back into the buffer in arrival order. The read that is waiting is then answered from the new line. A configuration word sets the instruction, the mode byte and its enable, the dummy count, and a dual-memory setting. With dual memory enabled, the flash address is halved, because two memories each supply half of every line.

All three data interfaces use valid/ready handshakes. A read request holds `rd_valid` and a word-aligned `rd_addr` steady until a cycle in which `rd_ready` is high. `rd_data` is valid in that cycle, and the request completes at that clock edge. Once `tx_valid` is raised it stays high, with `tx_data` unchanged, until the engine accepts the byte with `tx_ready`. The engine likewise holds `rx_valid` and `rx_data` until `rx_ready`. `rx_ready` is high for the whole of a fill and low at all other times, so the engine may return bytes at any pace during a fill. `cs_page` selects the upper flash page for the duration of a fill.

Top module: `flash_line_cache`

## Requirements
- R1: After reset `rd_ready`, `tx_valid`, `rx_ready` and `cs_page` are low, no line is cached so the first read misses, and the configuration holds 0x03A002EB: instruction 0xEB, mode byte 0xA0 enabled, two dummy bytes, dual memory off.
- R2: A read whose address A satisfies base <= A <= base + 1020 for a valid cached line causes no fill. `rd_ready` rises one cycle after the request is presented. `rd_data` holds buffer bytes A-base .. A-base+3, little-endian (the lowest offset in bits 7:0).
- R3: Any other read starts a fill. `rd_ready` stays low until the fill ends. The pending read is then answered from the new line.
- R4: A fill sends, in this order: the instruction (config bits 7:0); flash address bits 23:16, 15:8 and 7:0; the mode byte (config bits 23:16) only when config bit 25 is set; as many zero bytes as config bits 10:8; then exactly 1024 zero bytes.
- R5: Bytes received while the header is being sent are discarded. The next 1024 received bytes fill the buffer in order from offset 0.
- R6: The line-aligned address is the request address with its low 10 bits cleared. The flash address is that value shifted right by one when config bit 30 (dual memory) is set, and the value itself otherwise. The new cached base is the flash address times the number of buses.
- R7: `cs_page` equals bit 24 of the flash address during a fill, does not change during the fill, and is low outside a fill.
- R8: Every configuration write invalidates the cached line, including a line whose fill is in progress. The next read then misses and its header uses the new configuration.
- R9: `tx_valid` and `tx_data` hold steady until accepted. `rx_ready` stays high until the last byte of the fill has been received.
- R10: `rd_ready` is high for single cycles only. After a request completes, a new request is evaluated on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | ADDR_W | Byte address of the read, multiple of 4 |
| rd_ready | output | 1 | Read completes this cycle, data valid |
| rd_data | output | 32 | Read word, little-endian |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| tx_valid | output | 1 | Byte offered to the transfer engine |
| tx_ready | input | 1 | Engine accepts the byte |
| tx_data | output | 8 | Byte to send |
| rx_valid | input | 1 | Engine returns a byte |
| rx_ready | output | 1 | Sequencer accepts returned bytes (high during a fill) |
| rx_data | input | 8 | Returned byte |
| cs_page | output | 1 | Upper-page chip select during a fill |

## Verification
The reads mix directed addresses with random word addresses drawn from a few lines. Repeated lines separate hits from misses, and the bench counts fills to tell them apart. The words at offsets 0 and 1020 and the neighbouring addresses just outside the line probe both ends of the hit window. Several configuration words change the header length (4, 7 and 12 bytes) and the instruction byte. A behavioural engine with random back-pressure checks every transmitted byte against a header computed from the request. Its returned data is a function of flash address, so a wrong discard count, storage order or address scaling shows up in the returned words. An upper-page address and dual-memory addresses separate the chip-select and address-halving paths.

// File: rtl/flc_pkg.sv
package flc_pkg;

  localparam logic [31:0] CFG_RESET = 32'h03A0_02EB;

  localparam int INSTR_LSB = 0;
  localparam int DUMMY_LSB = 8;
  localparam int MODE_LSB  = 16;
  localparam int MODE_EN_B = 25;
  localparam int DUAL_B    = 30;

  typedef struct packed {
    logic [7:0] instr;
    logic [7:0] mode;
    logic       mode_en;
    logic [2:0] dummy;
  } hdr_cfg_t;

  function automatic logic [3:0] hdr_len(hdr_cfg_t h);
    return 4'd4 + {3'b000, h.mode_en} + {1'b0, h.dummy};
  endfunction

  function automatic logic [7:0] hdr_byte(hdr_cfg_t h, logic [23:0] a, logic [3:0] i);
    logic [7:0] b;
    case (i)
      4'd0:    b = h.instr;
      4'd1:    b = a[23:16];
      4'd2:    b = a[15:8];
      4'd3:    b = a[7:0];
      4'd4:    b = h.mode_en ? h.mode : 8'h00;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/flc_line_buf.sv
module flc_line_buf #(
  parameter int LINE_BYTES = 1024,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic [OFF_W-1:0] rd_off,
  output logic [31:0]      rd_word
);

  logic [7:0] mem [LINE_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [OFF_W-1:0] lane_idx;
    assign lane_idx = rd_off + OFF_W'(g);
    assign rd_word[8*g +: 8] = mem[lane_idx];
  end

endmodule

// File: rtl/flc_lookup.sv
module flc_lookup #(
  parameter int ADDR_W = 25,
  parameter int LINE_BYTES = 1024,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fill_start,
  input  logic              fill_done,
  input  logic [ADDR_W-1:0] new_base,
  input  logic              cfg_wr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);

  logic [ADDR_W-1:0] base_q;
  logic              valid_q;
  logic              stale_q;
  logic [ADDR_W:0]   last_word;
  logic [ADDR_W-1:0] delta;

  assign last_word = {1'b0, base_q} + (ADDR_W+1)'(LINE_BYTES - 4);
  assign hit   = valid_q && (addr >= base_q) && ({1'b0, addr} <= last_word);
  assign delta = addr - base_q;
  assign off   = delta[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      valid_q <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      if (fill_start) begin
        base_q  <= new_base;
        valid_q <= 1'b0;
      end else if (fill_done) begin
        valid_q <= !(stale_q || cfg_wr);
      end else if (cfg_wr) begin
        valid_q <= 1'b0;
      end
      if (cfg_wr)          stale_q <= 1'b1;
      else if (fill_start) stale_q <= 1'b0;
    end
  end

endmodule

// File: rtl/flc_fill_ctl.sv
module flc_fill_ctl
  import flc_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int CNT_W = $clog2(LINE_BYTES + 16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  hdr_cfg_t         hdr_in,
  input  logic [23:0]      addr_in,
  input  logic             page_in,
  output logic             busy,
  output logic             done,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_idx,
  output logic [7:0]       wr_byte,
  output logic             cs_page
);

  hdr_cfg_t         hdr_q;
  logic [23:0]      addr_q;
  logic             page_q;
  logic [CNT_W-1:0] hlen_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] tx_cnt;
  logic [CNT_W-1:0] rx_cnt;
  logic [CNT_W-1:0] data_idx;
  logic             tx_fire;
  logic             rx_fire;

  assign tx_valid = busy && (tx_cnt != total_q);
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_ready = busy;
  assign rx_fire  = rx_valid && busy;
  assign done     = rx_fire && (rx_cnt == total_q - CNT_W'(1));
  assign tx_data  = (tx_cnt < hlen_q) ? hdr_byte(hdr_q, addr_q, tx_cnt[3:0]) : 8'h00;
  assign cs_page  = busy && page_q;

  assign data_idx = rx_cnt - hlen_q;
  assign wr_en    = rx_fire && (rx_cnt >= hlen_q);
  assign wr_idx   = data_idx[OFF_W-1:0];
  assign wr_byte  = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      hdr_q   <= '0;
      addr_q  <= '0;
      page_q  <= 1'b0;
      hlen_q  <= '0;
      total_q <= '0;
      tx_cnt  <= '0;
      rx_cnt  <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      hdr_q   <= hdr_in;
      addr_q  <= addr_in;
      page_q  <= page_in;
      hlen_q  <= CNT_W'(hdr_len(hdr_in));
      total_q <= CNT_W'(hdr_len(hdr_in)) + CNT_W'(LINE_BYTES);
      tx_cnt  <= '0;
      rx_cnt  <= '0;
    end else if (busy) begin
      if (tx_fire) tx_cnt <= tx_cnt + CNT_W'(1);
      if (rx_fire) rx_cnt <= rx_cnt + CNT_W'(1);
      if (done)    busy   <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_line_cache.sv
module flash_line_cache
  import flc_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int LINE_BYTES = 1024,
  parameter int PAGE_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic [31:0]       rd_data,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              cs_page
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  hdr_cfg_t          cfg_hdr_q;
  logic              cfg_dual_q;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] flash_addr;
  logic [ADDR_W-1:0] new_base;
  logic              hit;
  logic [OFF_W-1:0]  off;
  logic              busy;
  logic              done;
  logic              start;
  logic              resp_q;
  logic [31:0]       data_q;
  logic [31:0]       buf_word;
  logic              wr_en;
  logic [OFF_W-1:0]  wr_idx;
  logic [7:0]        wr_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_hdr_q.instr   <= CFG_RESET[INSTR_LSB +: 8];
      cfg_hdr_q.mode    <= CFG_RESET[MODE_LSB +: 8];
      cfg_hdr_q.mode_en <= CFG_RESET[MODE_EN_B];
      cfg_hdr_q.dummy   <= CFG_RESET[DUMMY_LSB +: 3];
      cfg_dual_q        <= CFG_RESET[DUAL_B];
    end else if (cfg_we) begin
      cfg_hdr_q.instr   <= cfg_wdata[INSTR_LSB +: 8];
      cfg_hdr_q.mode    <= cfg_wdata[MODE_LSB +: 8];
      cfg_hdr_q.mode_en <= cfg_wdata[MODE_EN_B];
      cfg_hdr_q.dummy   <= cfg_wdata[DUMMY_LSB +: 3];
      cfg_dual_q        <= cfg_wdata[DUAL_B];
    end
  end

  assign aligned    = rd_addr & LINE_MASK;
  assign flash_addr = cfg_dual_q ? (aligned >> 1) : aligned;
  assign new_base   = cfg_dual_q ? {flash_addr[ADDR_W-2:0], 1'b0} : flash_addr;

  assign start = rd_valid && !busy && !resp_q && !hit;

  flc_lookup #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_lookup (
    .clk(clk), .rst_n(rst_n), .addr(rd_addr),
    .fill_start(start), .fill_done(done), .new_base(new_base),
    .cfg_wr(cfg_we), .hit(hit), .off(off)
  );

  flc_fill_ctl #(.LINE_BYTES(LINE_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr_in(cfg_hdr_q),
    .addr_in(flash_addr[23:0]), .page_in(flash_addr[PAGE_BIT]),
    .busy(busy), .done(done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .cs_page(cs_page)
  );

  flc_line_buf #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .rd_off(off), .rd_word(buf_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q <= 1'b0;
      data_q <= '0;
    end else if (resp_q) begin
      resp_q <= 1'b0;
    end else if (rd_valid && !busy && hit) begin
      resp_q <= 1'b1;
      data_q <= buf_word;
    end
  end

  assign rd_ready = resp_q;
  assign rd_data  = data_q;

endmodule

// File: rtl/flc_checker.sv
module flc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       cs_page
);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R9
  rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rx_valid));

  // R3
  no_ready_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !rd_ready);

  // R7
  page_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && $past(rx_ready) |-> $stable(cs_page));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);

endmodule

bind flash_line_cache flc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .cs_page(cs_page)
);

// File: tb/flash_line_cache_tb.sv
module flash_line_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 25;
  localparam int LINE = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_valid = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_ready;
  logic [31:0]       rd_data;
  logic              cfg_we = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic              tx_valid;
  logic              tx_ready = 1'b0;
  logic [7:0]        tx_data;
  logic              rx_valid = 1'b0;
  logic              rx_ready;
  logic [7:0]        rx_data = '0;
  logic              cs_page;

  flash_line_cache #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model state
  logic [31:0] cfg_m = 32'h03A0_02EB;
  bit          m_valid = 0;
  logic [ADDR_W-1:0] m_base = '0;

  // engine state
  logic [7:0] exp_hdr [12];
  int         exp_hlen = 7;
  int         fills = 0;
  int         idx = 0;
  int         hdr_bad = 0;
  int         dat_bad = 0;
  logic       fill_page = 0;
  logic [7:0] cap_hdr [4];
  bit         pend = 0;
  logic [7:0] pend_data = '0;

  function automatic logic [7:0] mem25(input logic [25:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ (a[23:16] + 8'h37) ^ (a[24] ? 8'hA5 : 8'h00);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // transfer engine model, driven at the falling edge
  initial begin
    @(posedge rst_n);
    forever begin
      bit rxf, tr, txf;
      logic [7:0] resp;
      @(negedge clk);
      rx_valid = pend;
      rx_data  = pend_data;
      rxf = pend && rx_ready;
      tr  = ($urandom % 4 != 0) && (!pend || rxf);
      tx_ready = tr;
      txf = tx_valid && tr;
      resp = 8'h00;
      if (txf) begin
        if (idx < exp_hlen) begin
          if (idx == 0) fill_page = cs_page;
          if (idx < 4) cap_hdr[idx] = tx_data;
          if (tx_data !== exp_hdr[idx]) hdr_bad++;
          resp = 8'hC3;
        end else begin
          if (tx_data !== 8'h00) dat_bad++;
          resp = mem25({1'b0, fill_page, cap_hdr[1], cap_hdr[2], cap_hdr[3]} + 26'(idx - exp_hlen));
        end
        idx++;
        if (idx == exp_hlen + LINE) begin
          idx = 0;
          fills++;
        end
      end
      if (txf) begin
        pend = 1;
        pend_data = resp;
      end else if (rxf) begin
        pend = 0;
      end
    end
  end

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
    m_valid = 0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
    logic [ADDR_W-1:0] aligned, fl, off;
    bit exp_hit, dual;
    int f0, cyc, k;
    logic [31:0] exp_w;
    aligned = a & ~ADDR_W'(LINE - 1);
    dual = cfg_m[30];
    fl = dual ? (aligned >> 1) : aligned;
    off = a - aligned;
    exp_hit = m_valid && (a >= m_base) && ({1'b0, a} <= {1'b0, m_base} + 26'd1020);
    exp_hlen = 4 + int'(cfg_m[25]) + int'(cfg_m[10:8]);
    exp_hdr[0] = cfg_m[7:0];
    exp_hdr[1] = fl[23:16];
    exp_hdr[2] = fl[15:8];
    exp_hdr[3] = fl[7:0];
    for (int i = 4; i < 12; i++) exp_hdr[i] = 8'h00;
    if (cfg_m[25]) exp_hdr[4] = cfg_m[23:16];
    hdr_bad = 0;
    dat_bad = 0;
    f0 = fills;
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr = a;
    cyc = 0;
    k = 0;
    while (k == 0) begin
      @(negedge clk);
      cyc++;
      if (rd_ready) k = 1;
      if (cyc > 20000) k = 1;
    end
    exp_w = '0;
    for (int j = 0; j < 4; j++)
      exp_w[8*j +: 8] = mem25({1'b0, fl} + {1'b0, off} + 26'(j));
    if (exp_hit) begin
      chk(cyc == 1, "R2", {tag, " hit latency"}, 32'(cyc), 32'd1);
      chk(fills == f0, "R2", {tag, " no fill on hit"}, 32'(fills), 32'(f0));
      chk(rd_data === exp_w, "R2", {tag, " hit data"}, rd_data, exp_w);
    end else begin
      chk(fills == f0 + 1, "R3", {tag, " one fill on miss"}, 32'(fills), 32'(f0 + 1));
      chk(hdr_bad == 0, "R4", {tag, " header bytes"}, 32'(hdr_bad), 32'd0);
      chk(dat_bad == 0, "R4", {tag, " zero data bytes"}, 32'(dat_bad), 32'd0);
      chk(fill_page === fl[24], "R7", {tag, " page during fill"}, 32'(fill_page), 32'(fl[24]));
      chk(rd_data === exp_w, "R5", {tag, " miss data (R6 address)"}, rd_data, exp_w);
    end
    m_valid = 1;
    m_base = aligned;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_ready === 1'b0, "R10", {tag, " single ready pulse"}, 32'(rd_ready), 32'd0);
    chk(cs_page === 1'b0, "R7", {tag, " page low after fill"}, 32'(cs_page), 32'd0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 190000 && !finished) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected finish", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] lines [4];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_ready === 1'b0, "R1", "reset rd_ready", 32'(rd_ready), 32'd0);
    chk(tx_valid === 1'b0, "R1", "reset tx_valid", 32'(tx_valid), 32'd0);
    chk(rx_ready === 1'b0, "R1", "reset rx_ready", 32'(rx_ready), 32'd0);
    chk(cs_page === 1'b0, "R1", "reset cs_page", 32'(cs_page), 32'd0);

    do_read(25'h000_1234 & ~25'h3, "R1 first access with reset config");
    do_read(25'h000_1000, "R2 line start");
    do_read(25'h000_13FC, "R2 last word");
    do_read(25'h000_1400, "R3 past line end");
    do_read(25'h000_13FC, "R3 below base");
    cfg_write(32'h03A0_02EB);
    do_read(25'h000_13FC, "R8 invalidated by config write");
    cfg_write(32'h0000_006B);
    do_read(25'h000_2008, "R8 new config header of 4");
    cfg_write(32'h025C_070B);
    do_read(25'h000_3010, "R4 header of 12");
    do_read(25'h1AB_CD40, "R7 upper page");
    do_read(25'h1AB_CD00, "R2 upper page hit");
    cfg_write(32'h43A0_02EB);
    do_read(25'h135_7A00, "R6 dual memory");
    do_read(25'h135_7BFC, "R6 dual memory hit");

    lines[0] = 25'h000_0000;
    lines[1] = 25'h0F0_0400;
    lines[2] = 25'h100_0800;
    lines[3] = 25'h1FF_FC00;
    for (int n = 0; n < 30; n++) begin
      logic [ADDR_W-1:0] ra;
      if ($urandom % 8 == 0) begin
        logic [31:0] c;
        c = {1'b0, 1'($urandom), 4'b0000, 1'($urandom), 1'b0, 8'($urandom),
             5'b0, 3'($urandom), 8'($urandom)};
        cfg_write(c);
      end
      ra = lines[$urandom % 4] + ADDR_W'(($urandom % 256) * 4);
      do_read(ra, "R2 R3 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule